// File: doc/BRIEF.md
# Aliased Atomic Register Bank

This block holds a bank of control words and decodes a memory-mapped register port into a word index and an update mode. Every word is reachable through four address windows. The windows share the same storage. A write through the first window replaces the word. A write through the second window inverts the bits that are 1 in the write data. A write through the third window sets those bits, and a write through the fourth window clears them. Software can therefore flip, raise or drop single control bits with one write and no read-modify-write sequence. This matters when several agents share one word.

The request side is a plain valid-qualified port. The bank accepts a request in every cycle that `req_valid` is high, so it never applies back-pressure and has no ready signal. A read returns its data on a registered response one cycle later, qualified by `rsp_valid`. The response also has no ready signal, so the consumer must take it in that cycle. The stored words are driven continuously on `regs_out` to the logic that the bank controls. Word k occupies bits [k*DATA_W +: DATA_W].

Address layout: bits [13:12] select the window (0 replace, 1 toggle, 2 set, 3 clear) and bits [11:2] select the word. Bits [1:0] are ignored. Any bits above 13 must be zero for the request to hit. ADDR_W must be at least 14.

Top module: `alias_reg_bank`

## Requirements
- R1: While reset is asserted and after its release, every stored word is RESET_VAL (zero by default) and `rsp_valid` is low.
- R2: A write with address bits [13:12] = 0 replaces the addressed word with `req_wdata`.
- R3: A write with address bits [13:12] = 1 makes the addressed word equal to its old value XOR `req_wdata`.
- R4: A write with address bits [13:12] = 2 makes the addressed word equal to its old value OR `req_wdata`.
- R5: A write with address bits [13:12] = 3 makes the addressed word equal to its old value AND NOT `req_wdata`.
- R6: A read through any of the four windows returns the addressed word unchanged and leaves every stored word as it was.
- R7: Address bits [11:2] give the word index and bits [1:0] are ignored. When the index is NUM_REGS or higher, or any address bit above 13 is set, a read returns zero and a write changes no word.
- R8: A write accepted at a clock edge shows on `regs_out` right after that edge. A read accepted in the next cycle returns the new value.
- R9: `rsp_valid` is high in exactly the cycles that follow a cycle with an accepted read. Writes and idle cycles produce no response.
- R10: A one-hot word written to the set or clear window changes only the bit at that position of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window [13:12], word [11:2] |
| req_wdata | input | DATA_W | Write data or bit mask |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read data |
| regs_out | output | NUM_REGS*DATA_W | All stored words, word k at [k*DATA_W +: DATA_W] |

## Verification
The properties assume that request signals are stable around the sampling edge. They also assume that a request raised during reset may be ignored: every antecedent is qualified with the reset state of the preceding cycle. The stimulus changes inputs only on falling edges and keeps `req_valid` low during reset. It mixes random windows, word indices past the end of the bank, and nonzero low address bits with one-hot and full-width data. Directed cases cover a write followed at once by a read, and reads of each word through all four windows.

// File: rtl/alias_pkg.sv
package alias_pkg;

  typedef enum logic [1:0] {
    WIN_REPLACE = 2'd0,
    WIN_TOGGLE  = 2'd1,
    WIN_SET     = 2'd2,
    WIN_CLEAR   = 2'd3
  } win_e;

  localparam int WIN_LSB = 12;
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = WIN_LSB - IDX_LSB;
  localparam int MAP_TOP = WIN_LSB + 2;

endpackage

// File: rtl/ar_addr_decode.sv
module ar_addr_decode
  import alias_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [SEL_W-1:0]  sel,
  output logic              hit
);

  logic [IDX_W-1:0] word_idx;
  logic             upper_clear;
  logic             unused_byte_lane;

  assign unused_byte_lane = ^addr[IDX_LSB-1:0];

  generate
    if (ADDR_W > MAP_TOP) begin : g_upper
      assign upper_clear = (addr[ADDR_W-1:MAP_TOP] == '0);
    end else begin : g_no_upper
      assign upper_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    win      = win_e'(addr[WIN_LSB +: 2]);
    word_idx = addr[IDX_LSB +: IDX_W];
    hit      = upper_clear && (32'(word_idx) < 32'(NUM_REGS));
    sel      = SEL_W'(word_idx);
  end

endmodule

// File: rtl/ar_word_update.sv
module ar_word_update
  import alias_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  win_e              win,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_next;

  always_comb begin
    unique case (win)
      WIN_REPLACE: q_next = wdata;
      WIN_TOGGLE:  q_next = q ^ wdata;
      WIN_SET:     q_next = q | wdata;
      WIN_CLEAR:   q_next = q & ~wdata;
      default:     q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RESET_VAL;
    else if (wr_en) q <= q_next;
  end

endmodule

// File: rtl/ar_read_path.sv
module ar_read_path #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic                       hit,
  input  logic [SEL_W-1:0]           sel,
  input  logic [NUM_REGS*DATA_W-1:0] words_flat,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata
);

  logic [DATA_W-1:0] words [NUM_REGS];
  logic [DATA_W-1:0] picked;

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_unpack
      assign words[k] = words_flat[k*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    picked = '0;
    if (hit && (32'(sel) < 32'(NUM_REGS))) picked = words[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= picked;
    end
  end

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_pkg::*;
#(
  parameter int               NUM_REGS  = 8,
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 14,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_out
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  win_e             win;
  logic [SEL_W-1:0] sel;
  logic             hit;
  logic             wr_go;
  logic             rd_go;
  logic [NUM_REGS-1:0] wr_onehot;

  ar_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .SEL_W   (SEL_W)
  ) u_decode (
    .addr(req_addr),
    .win (win),
    .sel (sel),
    .hit (hit)
  );

  assign wr_go = req_valid && req_write && hit;
  assign rd_go = req_valid && !req_write;

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
      assign wr_onehot[k] = wr_go && (sel == SEL_W'(k));

      ar_word_update #(
        .DATA_W   (DATA_W),
        .RESET_VAL(RESET_VAL)
      ) u_word (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_onehot[k]),
        .win  (win),
        .wdata(req_wdata),
        .q    (regs_out[k*DATA_W +: DATA_W])
      );
    end
  endgenerate

  ar_read_path #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_go),
    .hit       (hit),
    .sel       (sel),
    .words_flat(regs_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/alias_reg_bank_chk.sv
module alias_reg_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [DATA_W-1:0]          req_wdata,
  input logic                       rsp_valid,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [NUM_REGS*DATA_W-1:0] regs_out
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] words [NUM_REGS];
  logic [9:0]        idx_c;
  logic [1:0]        win_c;
  logic [SEL_W-1:0]  sel_c;
  logic              in_rng;
  logic              wr_ok;
  logic              wr_miss;
  logic              rd_acc;
  logic              unused_lane;

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_w
      assign words[k] = regs_out[k*DATA_W +: DATA_W];
    end
  endgenerate

  assign unused_lane = ^req_addr[1:0];
  assign idx_c   = req_addr[11:2];
  assign win_c   = req_addr[13:12];
  assign sel_c   = SEL_W'(idx_c);
  assign in_rng  = ((req_addr >> 14) == '0) && (32'(idx_c) < 32'(NUM_REGS));
  assign wr_ok   = rst_n && req_valid && req_write && in_rng;
  assign wr_miss = rst_n && req_valid && req_write && !in_rng;
  assign rd_acc  = rst_n && req_valid && !req_write;

  AST_REPLACE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && win_c == 2'd0) |-> words[$past(sel_c)] == $past(req_wdata)); // R2
  AST_TOGGLE_XORS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && win_c == 2'd1) |->
      (words[$past(sel_c)] ^ $past(words[sel_c])) == $past(req_wdata)); // R3
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && win_c == 2'd2) |->
      (words[$past(sel_c)] & $past(req_wdata)) == $past(req_wdata)); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && win_c == 2'd3) |-> (words[$past(sel_c)] & $past(req_wdata)) == '0); // R5
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !(req_valid && req_write)) |-> $stable(regs_out)); // R6
  AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_miss) |-> $stable(regs_out)); // R7
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!in_rng)) |-> rsp_rdata == '0); // R7
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc) |-> rsp_valid); // R9
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc)); // R9

endmodule

bind alias_reg_bank alias_reg_bank_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/alias_reg_bank_bench.sv
`timescale 1ns/1ps
module alias_reg_bank_bench;

  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int AW   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic [NREG*DW-1:0] regs_out;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  always #2.5 clk = ~clk;

  alias_reg_bank #(.NUM_REGS(NREG), .DATA_W(DW), .ADDR_W(AW)) u_alias_reg_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .regs_out(regs_out)
  );

  function automatic logic [DW-1:0] apply_win(logic [1:0] w, logic [DW-1:0] old, logic [DW-1:0] d);
    case (w)
      2'd0:    return d;
      2'd1:    return old ^ d;
      2'd2:    return old | d;
      default: return old & ~d;
    endcase
  endfunction

  function automatic string win_tag(logic [1:0] w);
    case (w)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    for (int k = 0; k < NREG; k++) chk(tag, regs_out[k*DW +: DW], model[k]);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9", 32'(rsp_valid), 32'd0);
  endtask

  task automatic op(bit wr, logic [1:0] w, int unsigned idx, logic [DW-1:0] d,
                    logic [1:0] lo, string tag);
    logic [DW-1:0] exp_rd;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {w, 10'(idx), lo};
    req_wdata = d;
    exp_rd    = (idx < NREG) ? model[idx] : '0;
    if (wr && idx < NREG) model[idx] = apply_win(w, model[idx], d);
    @(posedge clk); @(negedge clk);
    if (wr) begin
      chk("R9", 32'(rsp_valid), 32'd0);
      chk_all(tag);
    end else begin
      chk("R9", 32'(rsp_valid), 32'd1);
      chk(tag, rsp_rdata, exp_rd);
      chk_all("R6");
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NREG; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("R1");
    chk("R1", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    chk("R1", 32'(rsp_valid), 32'd0);

    op(1, 2'd0, 0, 32'hA5A5_0F0F, 2'b00, "R2");
    op(0, 2'd0, 0, '0, 2'b00, "R6");
    op(0, 2'd1, 0, '0, 2'b00, "R6");
    op(0, 2'd2, 0, '0, 2'b00, "R6");
    op(0, 2'd3, 0, '0, 2'b00, "R6");
    op(1, 2'd1, 0, 32'hFFFF_0000, 2'b00, "R3");
    op(1, 2'd2, 3, 32'h0000_0020, 2'b00, "R10");
    op(1, 2'd2, 3, 32'h8000_0000, 2'b00, "R10");
    op(1, 2'd3, 3, 32'h0000_0020, 2'b00, "R10");
    op(1, 2'd3, 0, 32'h00FF_00FF, 2'b00, "R5");
    op(1, 2'd0, NREG-1, 32'h1234_5678, 2'b00, "R2");
    op(0, 2'd0, NREG-1, '0, 2'b00, "R8");
    op(1, 2'd2, 5, 32'h0F00_0001, 2'b00, "R4");
    op(0, 2'd3, 5, '0, 2'b00, "R8");
    op(1, 2'd0, NREG, 32'hDEAD_BEEF, 2'b00, "R7");
    op(1, 2'd2, 1023, 32'hFFFF_FFFF, 2'b00, "R7");
    op(0, 2'd0, NREG, '0, 2'b00, "R7");
    op(0, 2'd1, 1023, '0, 2'b00, "R7");
    op(1, 2'd0, 2, 32'hCAFE_F00D, 2'b11, "R7");
    op(0, 2'd0, 2, '0, 2'b01, "R7");
    idle();

    for (int n = 0; n < 600; n++) begin
      logic [1:0]    w;
      int unsigned   idx;
      logic [DW-1:0] d;
      bit            wr;
      w   = 2'($urandom_range(0, 3));
      idx = $urandom_range(0, NREG + 3);
      wr  = ($urandom_range(0, 1) == 1);
      d   = ($urandom_range(0, 2) == 0) ? (32'd1 << $urandom_range(0, 31)) : $urandom();
      if ($urandom_range(0, 7) == 0) idle();
      else if (!wr) op(0, w, idx, '0, 2'($urandom_range(0, 3)), (idx < NREG) ? "R6" : "R7");
      else op(1, w, idx, d, 2'($urandom_range(0, 3)), (idx < NREG) ? win_tag(w) : "R7");
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule